// File: doc/BRIEF.md
# SCSI Controller Interrupt and Status Register Unit

This block is the host-side register front end of a simple SCSI bus controller. A processor reaches it through a byte-wide register port. The index of the register is taken from the bus address after a fixed right shift. The block holds a status byte, an interrupt-reason byte, a sequence-step value, a FIFO-flags byte, the last command, a transfer count and a bank of configuration bytes. A single level interrupt output follows the interrupt bit of the status register.

Commands written to the command register update the status registers directly. The bus phases, the target devices and the data movement are outside this block. The rest of the controller signals the end of a SCSI command with a one-cycle pulse that carries a status byte. If an interrupt is still pending when that pulse arrives, the completion is parked. It is reported one cycle after the host has read the interrupt-reason register.

Top module: `scsi_host_regfile`

## Requirements
- R1: After reset the interrupt output is low and every register reads 0. The exceptions are configuration byte 1 (index 8), which reads 0x07, and transfer-count high (index 2), which reads the chip identifier 0xA2. Register index = address >> 2, taking four bits.
- R2: A read of the reason register (index 5) returns its old value and then clears it to 0. The same read clears the terminal-count status bit (bit 4 of index 4), sets the sequence step (index 6) to 4 and drops the interrupt.
- R3: A completion pulse that arrives while the interrupt is high is parked, and its status byte is kept. A later pulse replaces the parked byte. The parked completion is reported in the cycle after the reason read that clears the interrupt.
- R4: Reporting a completion does four things. It sets the status to the status-phase bit (bit 1) alone and the reason to 0x18. It sets the sequence step to 4 and the flags (index 7) to 1. It stores the status byte at index 15 and raises the interrupt.
- R5: Flush (command 0x01) loads reason 0x08, zeroes the sequence step and the flags, and raises the interrupt.
- R6: Bus reset (0x03) loads reason 0x80. It raises the interrupt only when bit 6 of configuration byte 1 is 0.
- R7: Message accept (0x12) loads reason 0x20, zeroes the sequence step and the flags, and raises the interrupt. Pad (0x18) sets the status to terminal count (bit 4) alone, loads reason 0x08, zeroes the sequence step and raises the interrupt.
- R8: Enable selection (0x44) and disable selection (0x45) write 0 to the reason register and leave the interrupt as it is. Initiator command complete (0x11) loads reason 0x08, sets the message-in status bit (bit 0) and raises the interrupt.
- R9: Index 2 reads 0xA2 until it has been written once. Writes to indices 0 to 2 fill a write-side count. A known command with bit 7 set copies that count into the read-side count.
- R10: A read is accepted only with a size of 1 byte. A write is accepted with a size of 1 or 4 bytes. Any other access has no effect.
- R11: Command 0x02 is a hard reset with the same result as R1. An unknown command code changes nothing, and the command register (index 3) keeps its old value.
- R12: A completion pulse that arrives in the same cycle as a command write is parked. When a reason read and a reportable completion fall in the same cycle, the completion is applied after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte address; register index is bits 5:2 |
| bus_rd | input | 1 | Read request this cycle |
| bus_wr | input | 1 | Write request this cycle |
| bus_bytes | input | 3 | Access size in bytes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered at the edge of the accepted read |
| cpl_pulse | input | 1 | One-cycle completion event |
| cpl_status | input | 8 | Status byte of the completion |
| irq | output | 1 | Level interrupt, equal to status bit 7 |

## Verification
Two events can fall in the same cycle. A completion pulse can arrive together with a host read of the reason register. A completion pulse can also arrive together with a command write. The bench drives both pairs in directed cases, and its random phase drives them often by mixing completion pulses into reads and command writes. In each case the bench predicts, cycle by cycle, whether the completion is reported at once or parked, and when the interrupt rises again. The interrupt pin and the registers at indices 5 and 15 are compared against that prediction.

// File: rtl/scsi_regs_pkg.sv
// Shared constants and types for the SCSI host register unit.
// Assumes a 16-entry register index space and byte-wide data.
package scsi_regs_pkg;
    localparam int IDX_W  = 4;
    localparam int BYTE_W = 8;
    localparam int SEQ_W  = 3;

    localparam logic [IDX_W-1:0] IDX_TCLO  = 4'd0;
    localparam logic [IDX_W-1:0] IDX_TCMID = 4'd1;
    localparam logic [IDX_W-1:0] IDX_TCHI  = 4'd2;
    localparam logic [IDX_W-1:0] IDX_CMD   = 4'd3;
    localparam logic [IDX_W-1:0] IDX_STAT  = 4'd4;
    localparam logic [IDX_W-1:0] IDX_RSN   = 4'd5;
    localparam logic [IDX_W-1:0] IDX_SEQ   = 4'd6;
    localparam logic [IDX_W-1:0] IDX_FLG   = 4'd7;
    localparam logic [IDX_W-1:0] IDX_CPL   = 4'd15;
    localparam int CFG_BASE = 8;
    localparam int CFG_CNT  = 7;

    localparam logic [6:0] OP_NOP    = 7'h00;
    localparam logic [6:0] OP_FLUSH  = 7'h01;
    localparam logic [6:0] OP_HRST   = 7'h02;
    localparam logic [6:0] OP_BUSRST = 7'h03;
    localparam logic [6:0] OP_ICC    = 7'h11;
    localparam logic [6:0] OP_MSGACC = 7'h12;
    localparam logic [6:0] OP_PAD    = 7'h18;
    localparam logic [6:0] OP_SELON  = 7'h44;
    localparam logic [6:0] OP_SELOFF = 7'h45;

    localparam logic [BYTE_W-1:0] RSN_FC  = 8'h08;
    localparam logic [BYTE_W-1:0] RSN_BS  = 8'h10;
    localparam logic [BYTE_W-1:0] RSN_DC  = 8'h20;
    localparam logic [BYTE_W-1:0] RSN_RST = 8'h80;
    localparam logic [SEQ_W-1:0]  SEQ_DONE = 3'd4;
    localparam logic [BYTE_W-1:0] CFG1_INIT = 8'h07;
    localparam int CFG1_QUIET_BIT = 6;

    typedef struct packed {
        logic              known;
        logic              hard_rst;
        logic              ld_rsn;
        logic [BYTE_W-1:0] rsn;
        logic              clr_seq;
        logic              clr_flags;
        logic              set_mi;
        logic              tc_only;
        logic              raise;
        logic              raise_gated;
    } cmd_act_t;
endpackage

// File: rtl/scsi_cmd_decode.sv
// Maps a 7-bit command operation to a set of register actions.
// Purely combinational; unknown codes yield an all-zero action.
module scsi_cmd_decode
    import scsi_regs_pkg::*;
(
    input  logic [6:0] op,
    output cmd_act_t   act
);
    // Decode the operation into register actions
    always_comb begin
        act = '0;
        act.known = 1'b1;
        case (op)
            OP_NOP:    ;
            OP_FLUSH:  begin act.ld_rsn = 1'b1; act.rsn = RSN_FC; act.clr_seq = 1'b1;
                             act.clr_flags = 1'b1; act.raise = 1'b1; end
            OP_HRST:   act.hard_rst = 1'b1;
            OP_BUSRST: begin act.ld_rsn = 1'b1; act.rsn = RSN_RST; act.raise_gated = 1'b1; end
            OP_ICC:    begin act.ld_rsn = 1'b1; act.rsn = RSN_FC; act.set_mi = 1'b1;
                             act.raise = 1'b1; end
            OP_MSGACC: begin act.ld_rsn = 1'b1; act.rsn = RSN_DC; act.clr_seq = 1'b1;
                             act.clr_flags = 1'b1; act.raise = 1'b1; end
            OP_PAD:    begin act.ld_rsn = 1'b1; act.rsn = RSN_FC; act.clr_seq = 1'b1;
                             act.tc_only = 1'b1; act.raise = 1'b1; end
            OP_SELON, OP_SELOFF: begin act.ld_rsn = 1'b1; act.rsn = '0; end
            default:   act.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/scsi_irq_track.sv
// Owns the interrupt-pending bit and the parked completion.
// Assumes at most one completion pulse per cycle; a host command write
// in the same cycle (hold) forces the completion to be parked.
module scsi_irq_track #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              raise,
    input  logic              lower,
    input  logic              hold,
    input  logic              cpl_pulse,
    input  logic [BYTE_W-1:0] cpl_status,
    output logic              int_q,
    output logic              defer_q,
    output logic              report,
    output logic [BYTE_W-1:0] report_byte
);
    logic [BYTE_W-1:0] defer_byte_q;
    logic              park;

    // Decide whether a completion is reported now or parked
    always_comb begin
        report      = !int_q && !hold && (cpl_pulse || defer_q);
        report_byte = cpl_pulse ? cpl_status : defer_byte_q;
        park        = cpl_pulse && (int_q || hold);
    end

    // Interrupt bit and parked-completion storage
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            int_q        <= 1'b0;
            defer_q      <= 1'b0;
            defer_byte_q <= '0;
        end else begin
            if (raise || report) int_q <= 1'b1;
            else if (lower)      int_q <= 1'b0;
            if (park) begin
                defer_q      <= 1'b1;
                defer_byte_q <= cpl_status;
            end else if (report) begin
                defer_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/scsi_read_mux.sv
// Selects the read value for a register index. Combinational.
// Transfer-count high returns CHIP_ID until it has been written.
module scsi_read_mux
    import scsi_regs_pkg::*;
#(
    parameter logic [7:0] CHIP_ID = 8'hA2
) (
    input  logic [IDX_W-1:0]          idx,
    input  logic [3*BYTE_W-1:0]       tc_rd,
    input  logic                      tchi_written,
    input  logic [BYTE_W-1:0]         cmd,
    input  logic [BYTE_W-1:0]         status,
    input  logic [BYTE_W-1:0]         rsn,
    input  logic [SEQ_W-1:0]          seq,
    input  logic [BYTE_W-1:0]         flags,
    input  logic [CFG_CNT*BYTE_W-1:0] cfg,
    input  logic [BYTE_W-1:0]         cpl,
    output logic [BYTE_W-1:0]         data
);
    // Index decode of all readable registers
    always_comb begin
        data = '0;
        case (idx)
            IDX_TCLO:  data = tc_rd[0 +: BYTE_W];
            IDX_TCMID: data = tc_rd[BYTE_W +: BYTE_W];
            IDX_TCHI:  data = tchi_written ? tc_rd[2*BYTE_W +: BYTE_W] : CHIP_ID;
            IDX_CMD:   data = cmd;
            IDX_STAT:  data = status;
            IDX_RSN:   data = rsn;
            IDX_SEQ:   data = BYTE_W'(seq);
            IDX_FLG:   data = flags;
            IDX_CPL:   data = cpl;
            default: begin
                for (int k = 0; k < CFG_CNT; k++)
                    if (idx == IDX_W'(CFG_BASE + k)) data = cfg[k*BYTE_W +: BYTE_W];
            end
        endcase
    end
endmodule

// File: rtl/scsi_host_regfile.sv
// Host register front end of a SCSI controller: status, interrupt reason,
// sequence step, flags, command and configuration registers, one level
// interrupt. Assumes one host access per cycle and a synchronous reset.
module scsi_host_regfile
    import scsi_regs_pkg::*;
#(
    parameter int         ADDR_SHIFT = 2,
    parameter logic [7:0] CHIP_ID    = 8'hA2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_SHIFT+IDX_W-1:0] bus_addr,
    input  logic                        bus_rd,
    input  logic                        bus_wr,
    input  logic [2:0]                  bus_bytes,
    input  logic [BYTE_W-1:0]           bus_wdata,
    output logic [BYTE_W-1:0]           bus_rdata,
    input  logic                        cpl_pulse,
    input  logic [BYTE_W-1:0]           cpl_status,
    output logic                        irq
);
    localparam int TC_W = 3 * BYTE_W;

    logic [IDX_W-1:0]  idx;
    logic              rd_ok, wr_ok, cmd_wr, cmd_go, hard, rsn_rd, raise_cmd;
    cmd_act_t          act;
    logic [TC_W-1:0]   tc_wr_q, tc_rd_q;
    logic              tchi_written_q;
    logic [BYTE_W-1:0] cmd_q, rsn_q, flags_q, cpl_q, status, rd_mux;
    logic [SEQ_W-1:0]  seq_q;
    logic              stat_tc_q, stat_ph_q, stat_mi_q;
    logic [BYTE_W-1:0] cfg_q [CFG_CNT];
    logic [CFG_CNT*BYTE_W-1:0] cfg_flat;
    logic              int_q, defer_q, report;
    logic [BYTE_W-1:0] report_byte;

    generate
        if (ADDR_SHIFT > 0) begin : g_lsb
            logic unused_lsb;
            assign unused_lsb = ^bus_addr[ADDR_SHIFT-1:0];
        end
        for (genvar g = 0; g < CFG_CNT; g++) begin : g_cfg
            assign cfg_flat[g*BYTE_W +: BYTE_W] = cfg_q[g];
        end
    endgenerate

    // Access qualification and command-side strobes
    always_comb begin
        idx       = bus_addr[ADDR_SHIFT +: IDX_W];
        rd_ok     = bus_rd && !bus_wr && (bus_bytes == 3'd1);
        wr_ok     = bus_wr && !bus_rd && (bus_bytes == 3'd1 || bus_bytes == 3'd4);
        cmd_wr    = wr_ok && (idx == IDX_CMD);
        cmd_go    = cmd_wr && act.known;
        hard      = cmd_go && act.hard_rst;
        rsn_rd    = rd_ok && (idx == IDX_RSN);
        raise_cmd = cmd_go && (act.raise ||
                    (act.raise_gated && !cfg_q[0][CFG1_QUIET_BIT]));
        status    = {int_q, 2'b00, stat_tc_q, 2'b00, stat_ph_q, stat_mi_q};
        irq       = int_q;
    end

    scsi_cmd_decode u_dec (.op(bus_wdata[6:0]), .act(act));

    scsi_irq_track #(.BYTE_W(BYTE_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .soft_clr(hard), .raise(raise_cmd),
        .lower(rsn_rd), .hold(cmd_wr), .cpl_pulse(cpl_pulse),
        .cpl_status(cpl_status), .int_q(int_q), .defer_q(defer_q),
        .report(report), .report_byte(report_byte)
    );

    scsi_read_mux #(.CHIP_ID(CHIP_ID)) u_mux (
        .idx(idx), .tc_rd(tc_rd_q), .tchi_written(tchi_written_q), .cmd(cmd_q),
        .status(status), .rsn(rsn_q), .seq(seq_q), .flags(flags_q),
        .cfg(cfg_flat), .cpl(cpl_q), .data(rd_mux)
    );

    // Register state: read data, counts, status fields and configuration
    always_ff @(posedge clk) begin
        if (!rst_n || hard) begin
            bus_rdata <= '0; tc_wr_q <= '0; tc_rd_q <= '0; tchi_written_q <= 1'b0;
            cmd_q <= '0; rsn_q <= '0; flags_q <= '0; cpl_q <= '0; seq_q <= '0;
            stat_tc_q <= 1'b0; stat_ph_q <= 1'b0; stat_mi_q <= 1'b0;
            for (int k = 0; k < CFG_CNT; k++) cfg_q[k] <= (k == 0) ? CFG1_INIT : '0;
        end else begin
            if (rd_ok) bus_rdata <= rd_mux;
            if (rsn_rd) begin
                rsn_q     <= '0;
                stat_tc_q <= 1'b0;
                seq_q     <= SEQ_DONE;
            end
            if (wr_ok) begin
                if (idx == IDX_TCLO)  tc_wr_q[0 +: BYTE_W]        <= bus_wdata;
                if (idx == IDX_TCMID) tc_wr_q[BYTE_W +: BYTE_W]   <= bus_wdata;
                if (idx == IDX_TCHI) begin
                    tc_wr_q[2*BYTE_W +: BYTE_W] <= bus_wdata;
                    tchi_written_q <= 1'b1;
                end
                for (int k = 0; k < CFG_CNT; k++)
                    if (idx == IDX_W'(CFG_BASE + k)) cfg_q[k] <= bus_wdata;
            end
            if (cmd_go) begin
                cmd_q <= bus_wdata;
                if (bus_wdata[7])    tc_rd_q <= tc_wr_q;
                if (act.ld_rsn)      rsn_q   <= act.rsn;
                if (act.clr_seq)     seq_q   <= '0;
                if (act.clr_flags)   flags_q <= '0;
                if (act.set_mi)      stat_mi_q <= 1'b1;
                if (act.tc_only) begin
                    stat_tc_q <= 1'b1; stat_ph_q <= 1'b0; stat_mi_q <= 1'b0;
                end
            end
            if (report) begin
                stat_tc_q <= 1'b0; stat_ph_q <= 1'b1; stat_mi_q <= 1'b0;
                rsn_q   <= RSN_BS | RSN_FC;
                seq_q   <= SEQ_DONE;
                flags_q <= 8'h01;
                cpl_q   <= report_byte;
            end
        end
    end
endmodule

// File: rtl/scsi_host_regfile_chk.sv
// Property checker for scsi_host_regfile, attached by bind.
module scsi_host_regfile_chk #(
    parameter logic [7:0] CHIP_ID = 8'hA2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       rd_ok,
    input logic       bus_wr,
    input logic       wr_ok,
    input logic       rsn_rd,
    input logic       cmd_wr,
    input logic [7:0] bus_wdata,
    input logic [3:0] idx,
    input logic       cpl_pulse,
    input logic       defer_q,
    input logic       tchi_written_q,
    input logic [7:0] cfg1,
    input logic [7:0] bus_rdata
);
    // Reason read with no completion to report drops the interrupt
    assert_read_drops_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsn_rd && !cpl_pulse && !defer_q) |=> !irq);
    // Completion during a pending interrupt is parked
    assert_park_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_pulse && irq && !rsn_rd && !cmd_wr) |=> (irq && defer_q));
    // Completion coinciding with a non-reset command write is parked
    assert_park_on_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_pulse && cmd_wr && bus_wdata[6:0] != 7'h02) |=> defer_q);
    // Bus reset with reporting disabled leaves the interrupt low
    assert_busrst_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[6:0] == 7'h03 && cfg1[6] && !irq) |=> !irq);
    // Selection enable/disable never raises the interrupt
    assert_sel_no_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (bus_wdata[6:0] == 7'h44 || bus_wdata[6:0] == 7'h45) && !irq) |=> !irq);
    // Unwritten count-high reads as the chip identifier
    assert_chip_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && idx == 4'd2 && !tchi_written_q) |=> (bus_rdata == CHIP_ID));
    // Rejected write leaves configuration untouched
    assert_bad_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !wr_ok) |=> $stable(cfg1));
endmodule

bind scsi_host_regfile scsi_host_regfile_chk #(.CHIP_ID(CHIP_ID)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .rd_ok(rd_ok), .bus_wr(bus_wr),
    .wr_ok(wr_ok), .rsn_rd(rsn_rd), .cmd_wr(cmd_wr), .bus_wdata(bus_wdata),
    .idx(idx), .cpl_pulse(cpl_pulse), .defer_q(defer_q),
    .tchi_written_q(tchi_written_q), .cfg1(cfg_q[0]), .bus_rdata(bus_rdata)
);

// File: tb/scsi_host_regfile_tb.sv
// Self-checking bench: directed corner cases, then seeded random traffic
// compared against a cycle model built from the requirements.
module scsi_host_regfile_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_bytes = 3'd1;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cpl_pulse = 1'b0;
    logic [7:0] cpl_status = '0;
    logic       irq;

    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    scsi_host_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_bytes(bus_bytes), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpl_pulse(cpl_pulse), .cpl_status(cpl_status),
        .irq(irq)
    );

    // Expected-state model
    logic [7:0] m_tcw [3], m_tcr [3], m_cfg [7];
    logic [7:0] m_cmd, m_rsn, m_flg, m_cpl, m_defb;
    logic [2:0] m_seq;
    logic       m_tc, m_ph, m_mi, m_int, m_def, m_tchiw;

    task automatic m_reset();
        for (int k = 0; k < 3; k++) begin m_tcw[k] = 0; m_tcr[k] = 0; end
        for (int k = 0; k < 7; k++) m_cfg[k] = (k == 0) ? 8'h07 : 8'h00;
        m_cmd = 0; m_rsn = 0; m_flg = 0; m_cpl = 0; m_defb = 0; m_seq = 0;
        m_tc = 0; m_ph = 0; m_mi = 0; m_int = 0; m_def = 0; m_tchiw = 0;
    endtask

    function automatic logic [7:0] m_read(input int idx);
        case (idx)
            0, 1: return m_tcr[idx];
            2: return m_tchiw ? m_tcr[2] : 8'hA2;
            3: return m_cmd;
            4: return {m_int, 2'b00, m_tc, 2'b00, m_ph, m_mi};
            5: return m_rsn;
            6: return {5'b0, m_seq};
            7: return m_flg;
            15: return m_cpl;
            default: return m_cfg[idx-8];
        endcase
    endfunction

    function automatic bit known_op(input logic [6:0] op);
        return op inside {7'h00, 7'h01, 7'h02, 7'h03, 7'h11, 7'h12, 7'h18, 7'h44, 7'h45};
    endfunction

    task automatic m_update(input bit rd, input bit wr, input int idx, input logic [7:0] wd,
                            input int bytes, input bit cp, input logic [7:0] cs);
        bit rdok, wrok, cmdw, raise, lower, rep, park, old;
        logic [7:0] rb;
        rdok = rd && !wr && bytes == 1;
        wrok = wr && !rd && (bytes == 1 || bytes == 4);
        cmdw = wrok && idx == 3;
        old = m_int; raise = 0; lower = 0;
        if (cmdw && wd[6:0] == 7'h02) begin m_reset(); return; end
        if (rdok && idx == 5) begin m_rsn = 0; m_tc = 0; m_seq = 4; lower = 1; end
        if (wrok) begin
            if (idx <= 2) m_tcw[idx] = wd;
            if (idx == 2) m_tchiw = 1;
            if (idx >= 8 && idx <= 14) m_cfg[idx-8] = wd;
        end
        if (cmdw && known_op(wd[6:0])) begin
            m_cmd = wd;
            if (wd[7]) for (int k = 0; k < 3; k++) m_tcr[k] = m_tcw[k];
            case (wd[6:0])
                7'h01: begin m_rsn = 8'h08; m_seq = 0; m_flg = 0; raise = 1; end
                7'h03: begin m_rsn = 8'h80; raise = !m_cfg[0][6]; end
                7'h11: begin m_rsn = 8'h08; m_mi = 1; raise = 1; end
                7'h12: begin m_rsn = 8'h20; m_seq = 0; m_flg = 0; raise = 1; end
                7'h18: begin m_rsn = 8'h08; m_seq = 0; m_tc = 1; m_ph = 0; m_mi = 0; raise = 1; end
                7'h44, 7'h45: m_rsn = 0;
                default: ;
            endcase
        end
        rep  = !old && !cmdw && (cp || m_def);
        park = cp && (old || cmdw);
        rb   = cp ? cs : m_defb;
        if (rep) begin
            m_tc = 0; m_ph = 1; m_mi = 0; m_rsn = 8'h18; m_seq = 4; m_flg = 1; m_cpl = rb;
        end
        if (raise || rep) m_int = 1; else if (lower) m_int = 0;
        if (park) begin m_def = 1; m_defb = cs; end else if (rep) m_def = 0;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One host cycle: drive after negedge, compare at the following negedge
    task automatic step(input bit rd, input bit wr, input int idx, input logic [7:0] wd,
                        input int bytes, input bit cp, input logic [7:0] cs, input string req);
        logic [7:0] exp_rd;
        bit rdok;
        exp_rd = m_read(idx);
        rdok = rd && !wr && bytes == 1;
        bus_rd = rd; bus_wr = wr; bus_addr = 6'(idx << 2); bus_wdata = wd;
        bus_bytes = 3'(bytes); cpl_pulse = cp; cpl_status = cs;
        m_update(rd, wr, idx, wd, bytes, cp, cs);
        @(posedge clk); @(negedge clk);
        bus_rd = 0; bus_wr = 0; cpl_pulse = 0;
        if (rdok) check({req, " rdata"}, bus_rdata, exp_rd);
        check({req, " irq"}, irq, m_int);
    endtask

    task automatic rd_reg(input int idx, input string req);
        step(1, 0, idx, 8'h00, 1, 0, 8'h00, req);
    endtask
    task automatic wr_reg(input int idx, input logic [7:0] v, input string req);
        step(0, 1, idx, v, 1, 0, 8'h00, req);
    endtask
    task automatic cpl(input logic [7:0] s, input string req);
        step(0, 0, 0, 8'h00, 1, 1, s, req);
    endtask

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every register
        for (int i = 0; i < 16; i++) rd_reg(i, "R1");
        // R9: chip identifier, then reload of the read-side count
        wr_reg(0, 8'h11, "R9"); wr_reg(1, 8'h22, "R9");
        rd_reg(2, "R9");
        wr_reg(2, 8'h33, "R9");
        rd_reg(0, "R9");
        wr_reg(3, 8'h80, "R9");
        for (int i = 0; i < 3; i++) rd_reg(i, "R9");
        // R5 and R2: flush, then clearing read
        wr_reg(3, 8'h01, "R5");
        rd_reg(6, "R5"); rd_reg(5, "R2"); rd_reg(5, "R2"); rd_reg(6, "R2");
        // R7: message accept and pad
        wr_reg(3, 8'h12, "R7"); rd_reg(5, "R7");
        wr_reg(3, 8'h18, "R7"); rd_reg(4, "R7"); rd_reg(5, "R7"); rd_reg(4, "R2");
        // R8: initiator complete, selection enable/disable
        wr_reg(3, 8'h11, "R8"); rd_reg(4, "R8"); rd_reg(5, "R8");
        wr_reg(3, 8'h44, "R8"); rd_reg(5, "R8");
        wr_reg(3, 8'h01, "R8"); wr_reg(3, 8'h45, "R8"); rd_reg(5, "R8");
        rd_reg(5, "R8");
        // R6: bus reset with reporting enabled, then disabled
        wr_reg(3, 8'h03, "R6"); rd_reg(5, "R6");
        wr_reg(8, 8'h47, "R6"); wr_reg(3, 8'h03, "R6"); rd_reg(4, "R6"); rd_reg(5, "R6");
        // R4 and R3: direct report, then parking with replacement
        cpl(8'h02, "R4"); rd_reg(4, "R4"); rd_reg(7, "R4"); rd_reg(15, "R4"); rd_reg(5, "R4");
        wr_reg(3, 8'h01, "R3"); cpl(8'h0A, "R3"); cpl(8'h05, "R3");
        rd_reg(15, "R3"); rd_reg(5, "R3"); rd_reg(15, "R3"); rd_reg(15, "R3"); rd_reg(5, "R3");
        // R12: completion with a command write; completion with a reason read
        step(0, 1, 3, 8'h44, 1, 1, 8'h3C, "R12"); rd_reg(15, "R12"); rd_reg(5, "R12");
        step(1, 0, 5, 8'h00, 1, 1, 8'h77, "R12"); rd_reg(5, "R12"); rd_reg(15, "R12");
        // R10: rejected sizes
        step(0, 1, 9, 8'h5A, 2, 0, 8'h00, "R10"); rd_reg(9, "R10");
        step(0, 1, 9, 8'h6B, 4, 0, 8'h00, "R10"); rd_reg(9, "R10");
        wr_reg(3, 8'h01, "R10"); step(1, 0, 5, 8'h00, 4, 0, 8'h00, "R10"); rd_reg(5, "R10");
        // R11: unknown command, then hard reset command
        wr_reg(3, 8'h7F, "R11"); rd_reg(3, "R11"); rd_reg(2, "R11");
        wr_reg(10, 8'hC3, "R11"); wr_reg(3, 8'h02, "R11");
        rd_reg(8, "R11"); rd_reg(10, "R11"); rd_reg(2, "R11");
        // Random phase over all requirements
        begin
            int unsigned seed;
            logic [6:0] ops [10];
            seed = $urandom(32'h5EED);
            ops = '{7'h00, 7'h01, 7'h03, 7'h11, 7'h12, 7'h18, 7'h44, 7'h45, 7'h7F, 7'h02};
            for (int n = 0; n < 4000; n++) begin
                int kind, idx, bytes;
                bit cp;
                logic [7:0] v;
                kind = $urandom_range(0, 9);
                idx = $urandom_range(0, 15);
                cp = ($urandom_range(0, 3) == 0);
                v = 8'($urandom);
                bytes = ($urandom_range(0, 7) == 0) ? 2 : 1;
                case (kind)
                    0, 1, 2: begin
                        v[6:0] = ops[($urandom_range(0, 60) == 0) ? 9 : $urandom_range(0, 8)];
                        step(0, 1, 3, v, bytes, cp, 8'($urandom), "rand");
                    end
                    3, 4: step(1, 0, 5, 8'h00, bytes, cp, 8'($urandom), "rand");
                    5, 6: step(1, 0, idx, 8'h00, bytes, cp, 8'($urandom), "rand");
                    7: step(0, 1, (idx < 8) ? idx % 3 : idx, v, bytes, cp, 8'($urandom), "rand");
                    default: step(0, 0, 0, 8'h00, 1, cp, 8'($urandom), "rand");
                endcase
            end
        end
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule